// File: doc/BRIEF.md
# Interleaved SECDED Memory Wrapper

This block wraps a plain row-organised storage array and protects every logical word with an extended Hamming code. The code corrects any single flipped bit and detects any two flipped bits. Each physical row holds several logical words. Their code bits are interleaved column by column, so cell neighbours always belong to different words. A particle strike that upsets a short run of adjacent cells therefore produces at most one flipped bit per word, and every word in the row can still be repaired on read.

The user side has one address, a write strobe with write data, and a read strobe. Corrected read data appears one cycle after the read strobe, together with a corrected flag and an uncorrectable flag. A fault-injection port flips a run of adjacent physical cells in one row, which lets a bench model multi-cell upsets. A build-time parameter selects a lighter variant that stores only an even parity bit per word. That variant can detect a single error but cannot repair it.

Top module: `ilv_ecc_mem`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_valid, err_corr and err_uncorr are low.
- R2: rd_valid is high exactly in the cycle after a cycle with rd_en high, and rd_data and the flags are valid in that cycle. A word read back with no injected fault equals the last data written to its address, with both flags low.
- R3: A write changes only the addressed word. The other words sharing its physical row keep their values.
- R4: The low log2(ILV) address bits select the word slot and the upper bits select the row. Codeword bit b of the word in slot s is stored in physical column b*ILV+s.
- R5: In the SECDED variant, one flipped cell in a word is repaired on read and err_corr is set. This holds for data bits, check bits and the overall parity bit (codeword bit 0).
- R6: A run of 1 to ILV adjacent flipped cells in one row leaves every word of that row readable with its written data. Exactly the words the run touches report err_corr, and the other words report no flag.
- R7: Two flipped bits in one SECDED word set err_uncorr and clear err_corr, and rd_data returns the stored data bits without any correction. The Hamming positions 1..21 map to codeword bits 1..21. The 16 data bits fill the positions that are not powers of two in ascending order, so codeword bit 3 holds data bit 0 and bit 4 holds a check bit.
- R8: A run of ILV+1 adjacent flipped cells hits one word twice, and that word reports err_uncorr.
- R9: An injection with inj_en high inverts physical columns inj_col through inj_col+inj_len-1 of row inj_row only. Columns past the row end are ignored.
- R10: In the parity variant, data bit i is stored at codeword bit i and the even parity bit at codeword bit 16. A single flipped data bit sets err_uncorr, never err_corr, and rd_data returns the flipped data.
- R11: While rd_en is low, rd_data holds its last value, even across writes to the address last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write the addressed word |
| rd_en | input | 1 | Read the addressed word |
| addr | input | ADDR_W | Logical word address {row, slot} |
| wr_data | input | DATA_W | Write data |
| inj_en | input | 1 | Apply a fault-injection burst this cycle |
| inj_row | input | ROW_W | Row receiving the burst |
| inj_col | input | COL_W | First physical column of the burst |
| inj_len | input | LEN_W | Number of adjacent columns to invert |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Corrected read data |
| err_corr | output | 1 | A single error was repaired |
| err_uncorr | output | 1 | An error was detected that is not repaired |

## Verification
The bench builds two copies with the default 16-bit words, interleave factor 4 and 16 rows. One copy uses SECDED and the other uses parity, and both receive the same stimulus. The SECDED copy's 88-column rows let bursts start at both row edges, so clipping and wrap-free slot coverage can be checked. The interleave factor of 4 puts bursts of 4 and 5 cells on either side of the boundary between correctable and uncorrectable. The parity copy shows the same single flip being flagged but not repaired.

// File: rtl/ecc_ilv_pkg.sv
package ecc_ilv_pkg;

    typedef enum logic {
        PROT_SECDED = 1'b0,
        PROT_PARITY = 1'b1
    } prot_e;

    typedef struct packed {
        logic fixed;   // single error repaired
        logic fatal;   // error seen, data left as stored
    } rd_flags_t;

    // number of Hamming check bits needed for dw data bits
    function automatic int chk_bits(int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic int cw_width(int dw, prot_e prot);
        if (prot == PROT_SECDED) return dw + chk_bits(dw) + 1;
        return dw + 1;
    endfunction

    function automatic int len_width(int ilv);
        return $clog2(ilv) + 1;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_ilv_pkg::*;
#(
    parameter int    DATA_W = 16,
    parameter prot_e PROT   = PROT_SECDED,
    parameter int    CW_W   = cw_width(DATA_W, PROT)
) (
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   cw
);

    generate
        if (PROT == PROT_SECDED) begin : g_secded
            localparam int NCHK = chk_bits(DATA_W);
            localparam int HN   = DATA_W + NCHK;

            logic [HN:1]     hd;
            logic [NCHK-1:0] par;

            // data bits into the non-power-of-two positions
            for (genvar i = 1; i <= HN; i++) begin : g_place
                if ((i & (i - 1)) == 0) begin : g_hole
                    assign hd[i] = 1'b0;
                end else begin : g_bit
                    assign hd[i] = data[i - $clog2(i + 1) - 1];
                end
            end

            always_comb begin
                par = '0;
                for (int p = 0; p < NCHK; p++) begin
                    for (int i = 1; i <= HN; i++) begin
                        if (((i >> p) & 1) == 1) par[p] = par[p] ^ hd[i];
                    end
                end
            end

            for (genvar i = 1; i <= HN; i++) begin : g_out
                if ((i & (i - 1)) == 0) begin : g_chk
                    assign cw[i] = par[$clog2(i)];
                end else begin : g_dat
                    assign cw[i] = hd[i];
                end
            end
            assign cw[0] = ^{par, data};
        end else begin : g_parity
            assign cw = {^data, data};
        end
    endgenerate

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_ilv_pkg::*;
#(
    parameter int    DATA_W = 16,
    parameter prot_e PROT   = PROT_SECDED,
    parameter int    CW_W   = cw_width(DATA_W, PROT)
) (
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output rd_flags_t         flags
);

    generate
        if (PROT == PROT_SECDED) begin : g_secded
            localparam int NCHK = chk_bits(DATA_W);
            localparam int HN   = DATA_W + NCHK;

            logic [NCHK-1:0] syn;
            logic            ov;
            logic [HN:0]     flip;

            always_comb begin
                syn = '0;
                for (int p = 0; p < NCHK; p++) begin
                    for (int i = 1; i <= HN; i++) begin
                        if (((i >> p) & 1) == 1) syn[p] = syn[p] ^ cw[i];
                    end
                end
            end

            assign ov = ^cw;

            // a flip is applied only for an odd overall check
            always_comb begin
                flip    = '0;
                flip[0] = ov && (syn == '0);
                for (int i = 1; i <= HN; i++) begin
                    flip[i] = ov && (syn == NCHK'(i));
                end
            end

            assign flags.fixed = ov && (syn <= NCHK'(HN));
            assign flags.fatal = (!ov && (syn != '0)) || (ov && (syn > NCHK'(HN)));

            for (genvar i = 1; i <= HN; i++) begin : g_ext
                if ((i & (i - 1)) != 0) begin : g_dat
                    assign data[i - $clog2(i + 1) - 1] = cw[i] ^ flip[i];
                end
            end
        end else begin : g_parity
            assign data        = cw[DATA_W-1:0];
            assign flags.fixed = 1'b0;
            assign flags.fatal = ^cw;
        end
    endgenerate

endmodule

// File: rtl/ilv_map.sv
module ilv_map #(
    parameter int CW_W   = 22,
    parameter int ILV    = 4,
    parameter int PHYS_W = CW_W * ILV,
    parameter int SLOT_W = $clog2(ILV)
) (
    input  logic [PHYS_W-1:0] row,
    input  logic [SLOT_W-1:0] slot,
    input  logic [CW_W-1:0]   wcw,
    output logic [CW_W-1:0]   rcw,
    output logic [PHYS_W-1:0] spread,
    output logic [PHYS_W-1:0] smask
);

    // column = codeword bit * ILV + slot
    for (genvar b = 0; b < CW_W; b++) begin : g_bit
        for (genvar s = 0; s < ILV; s++) begin : g_slot
            assign spread[b*ILV+s] = wcw[b];
            assign smask[b*ILV+s]  = (slot == SLOT_W'(s));
        end
    end

    always_comb begin
        rcw = '0;
        for (int s = 0; s < ILV; s++) begin
            if (slot == SLOT_W'(s)) begin
                for (int b = 0; b < CW_W; b++) rcw[b] = row[b*ILV+s];
            end
        end
    end

endmodule

// File: rtl/burst_mask.sv
module burst_mask #(
    parameter int PHYS_W = 88,
    parameter int COL_W  = $clog2(PHYS_W),
    parameter int LEN_W  = 3
) (
    input  logic              en,
    input  logic [COL_W-1:0]  col,
    input  logic [LEN_W-1:0]  len,
    output logic [PHYS_W-1:0] mask
);

    always_comb begin
        for (int j = 0; j < PHYS_W; j++) begin
            mask[j] = en && (j >= int'(col)) && (j < int'(col) + int'(len));
        end
    end

endmodule

// File: rtl/ilv_ecc_mem.sv
module ilv_ecc_mem
    import ecc_ilv_pkg::*;
#(
    parameter int    DATA_W = 16,
    parameter int    ILV    = 4,
    parameter int    ROWS   = 16,
    parameter prot_e PROT   = PROT_SECDED,
    localparam int   SLOT_W = $clog2(ILV),
    localparam int   ROW_W  = $clog2(ROWS),
    localparam int   ADDR_W = ROW_W + SLOT_W,
    localparam int   CW_W   = cw_width(DATA_W, PROT),
    localparam int   PHYS_W = CW_W * ILV,
    localparam int   COL_W  = $clog2(PHYS_W),
    localparam int   LEN_W  = len_width(ILV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inj_en,
    input  logic [ROW_W-1:0]  inj_row,
    input  logic [COL_W-1:0]  inj_col,
    input  logic [LEN_W-1:0]  inj_len,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_corr,
    output logic              err_uncorr
);

    logic [PHYS_W-1:0] mem [ROWS];

    logic [ROW_W-1:0]  a_row;
    logic [SLOT_W-1:0] a_slot;
    logic [PHYS_W-1:0] row_cur;
    logic [PHYS_W-1:0] row_wr;
    logic [PHYS_W-1:0] spread;
    logic [PHYS_W-1:0] smask;
    logic [PHYS_W-1:0] flip;
    logic [CW_W-1:0]   wcw;
    logic [CW_W-1:0]   rcw;
    logic [CW_W-1:0]   cw_q;
    logic              valid_q;
    rd_flags_t         flags;

    assign a_row   = addr[ADDR_W-1:SLOT_W];
    assign a_slot  = addr[SLOT_W-1:0];
    assign row_cur = mem[a_row];

    ecc_enc #(.DATA_W(DATA_W), .PROT(PROT), .CW_W(CW_W)) u_enc (
        .data (wr_data),
        .cw   (wcw)
    );

    ilv_map #(.CW_W(CW_W), .ILV(ILV), .PHYS_W(PHYS_W), .SLOT_W(SLOT_W)) u_map (
        .row    (row_cur),
        .slot   (a_slot),
        .wcw    (wcw),
        .rcw    (rcw),
        .spread (spread),
        .smask  (smask)
    );

    burst_mask #(.PHYS_W(PHYS_W), .COL_W(COL_W), .LEN_W(LEN_W)) u_burst (
        .en   (inj_en),
        .col  (inj_col),
        .len  (inj_len),
        .mask (flip)
    );

    assign row_wr = (row_cur & ~smask) | (spread & smask);

    // storage update: write merge, then injected upsets on top
    always_ff @(posedge clk) begin
        if (wr_en && inj_en && (a_row == inj_row)) begin
            mem[a_row] <= row_wr ^ flip;
        end else begin
            if (wr_en)  mem[a_row]   <= row_wr;
            if (inj_en) mem[inj_row] <= mem[inj_row] ^ flip;
        end
    end

    // read stage: capture codeword, decode behind the register
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cw_q    <= '0;
        end else begin
            valid_q <= rd_en;
            if (rd_en) cw_q <= rcw;
        end
    end

    ecc_dec #(.DATA_W(DATA_W), .PROT(PROT), .CW_W(CW_W)) u_dec (
        .cw    (cw_q),
        .data  (rd_data),
        .flags (flags)
    );

    assign rd_valid   = valid_q;
    assign err_corr   = valid_q && flags.fixed;
    assign err_uncorr = valid_q && flags.fatal;

endmodule

// File: rtl/ilv_ecc_mem_chk.sv
module ilv_ecc_mem_chk
    import ecc_ilv_pkg::*;
#(
    parameter int    DATA_W = 16,
    parameter prot_e PROT   = PROT_SECDED
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              err_corr,
    input logic              err_uncorr
);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!rd_valid && !err_corr && !err_uncorr));

    a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r2_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!err_corr && !err_uncorr));

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !(err_corr && err_uncorr));

    a_r10_parity_never_repairs: assert property (@(posedge clk) disable iff (rst)
        (PROT == PROT_PARITY) |-> !err_corr);

    a_r11_data_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

bind ilv_ecc_mem ilv_ecc_mem_chk #(.DATA_W(DATA_W), .PROT(PROT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr)
);

// File: tb/ilv_ecc_mem_bench.sv
module ilv_ecc_mem_bench;
    import ecc_ilv_pkg::*;

    localparam int DATA_W = 16;
    localparam int ILV    = 4;
    localparam int ROWS   = 16;
    localparam int ADDR_W = 6;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 7;
    localparam int LEN_W  = 3;
    localparam int NCOL   = 88;   // SECDED row width: 22 bits * 4

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en, rd_en, inj_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data;
    logic [ROW_W-1:0]  inj_row;
    logic [COL_W-1:0]  inj_col;
    logic [LEN_W-1:0]  inj_len;

    logic              v_s, c_s, u_s, v_p, c_p, u_p;
    logic [DATA_W-1:0] d_s, d_p;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ilv_ecc_mem #(.DATA_W(DATA_W), .ILV(ILV), .ROWS(ROWS), .PROT(PROT_SECDED)) u_ilv_ecc_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .inj_en(inj_en), .inj_row(inj_row), .inj_col(inj_col), .inj_len(inj_len),
        .rd_valid(v_s), .rd_data(d_s), .err_corr(c_s), .err_uncorr(u_s)
    );

    ilv_ecc_mem #(.DATA_W(DATA_W), .ILV(ILV), .ROWS(ROWS), .PROT(PROT_PARITY)) u_ilv_ecc_mem_par (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .inj_en(inj_en), .inj_row(inj_row), .inj_col(inj_col), .inj_len(inj_len),
        .rd_valid(v_p), .rd_data(d_p), .err_corr(c_p), .err_uncorr(u_p)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(int row, int slot, int seed);
        return DATA_W'(row * 16'h1111 ^ slot * 16'h0f0f ^ seed * 16'h2493);
    endfunction

    task automatic wr(int row, int slot, logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(row * ILV + slot); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int row, int slot);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(row * ILV + slot);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic inj(int row, int col, int len);
        @(negedge clk);
        inj_en = 1'b1; inj_row = ROW_W'(row); inj_col = COL_W'(col); inj_len = LEN_W'(len);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic fill_row(int row, int seed);
        for (int s = 0; s < ILV; s++) wr(row, s, pat(row, s, seed));
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_en = 0; rd_en = 0; inj_en = 0;
        addr = '0; wr_data = '0; inj_row = '0; inj_col = '0; inj_len = '0;
        repeat (3) @(negedge clk);
        chk("R1", "rd_valid in reset", 32'(v_s), 0);
        chk("R1", "flags in reset", 32'({c_s, u_s, c_p, u_p}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rd_valid after reset", 32'(v_s), 0);
    endtask

    task automatic t_clean;
        for (int r = 0; r < ROWS; r += 15) fill_row(r, 1);
        for (int r = 0; r < ROWS; r += 15) begin
            for (int s = 0; s < ILV; s++) begin
                rd(r, s);
                chk("R2", "valid", 32'(v_s), 1);
                chk("R4", "secded data", 32'(d_s), 32'(pat(r, s, 1)));
                chk("R2", "secded flags", 32'({c_s, u_s}), 0);
                chk("R4", "parity data", 32'(d_p), 32'(pat(r, s, 1)));
                chk("R2", "parity flags", 32'({c_p, u_p}), 0);
            end
        end
        @(negedge clk);
        chk("R2", "valid drops one cycle later", 32'(v_s), 0);
    endtask

    task automatic t_partial;
        fill_row(3, 2);
        wr(3, 2, 16'hbeef);
        for (int s = 0; s < ILV; s++) begin
            rd(3, s);
            chk("R3", "neighbour kept", 32'(d_s), (s == 2) ? 32'h0000beef : 32'(pat(3, s, 2)));
        end
    endtask

    task automatic t_single;
        int cols[5] = '{0, 5, 14, 43, 87};
        foreach (cols[i]) begin
            int c = cols[i];
            fill_row(1, 3 + i);
            inj(1, c, 1);
            for (int s = 0; s < ILV; s++) begin
                rd(1, s);
                chk("R5", "data repaired", 32'(d_s), 32'(pat(1, s, 3 + i)));
                chk("R5", "corr flag", 32'(c_s), 32'(s == c % ILV));
                chk("R5", "uncorr flag", 32'(u_s), 0);
            end
        end
    endtask

    task automatic t_bursts;
        int cols[4] = '{0, 3, 41, 84};
        foreach (cols[i]) begin
            for (int k = 1; k <= ILV; k++) begin
                int c = cols[i];
                fill_row(6, k + i * 4);
                fill_row(7, 9);
                inj(6, c, k);
                for (int s = 0; s < ILV; s++) begin
                    bit hit = 1'b0;
                    for (int j = 0; j < k; j++) if ((c + j) % ILV == s) hit = 1'b1;
                    rd(6, s);
                    chk("R6", "burst data", 32'(d_s), 32'(pat(6, s, k + i * 4)));
                    chk("R6", "burst flags", 32'({c_s, u_s}), {30'd0, hit, 1'b0});
                end
                rd(7, c % ILV);
                chk("R9", "other row untouched", 32'({c_s, u_s}), 0);
            end
        end
    endtask

    task automatic t_double;
        wr(9, 0, 16'ha5c3);
        inj(9, 12, 1);
        inj(9, 16, 1);
        rd(9, 0);
        chk("R7", "uncorr flag", 32'(u_s), 1);
        chk("R7", "corr flag", 32'(c_s), 0);
        chk("R7", "raw data", 32'(d_s), 32'(16'ha5c3 ^ 16'h0001));
    endtask

    task automatic t_long;
        for (int c = 8; c <= 9; c++) begin
            fill_row(8, c);
            inj(8, c, ILV + 1);
            for (int s = 0; s < ILV; s++) begin
                rd(8, s);
                if (s == c % ILV) begin
                    chk("R8", "double-hit slot", 32'({c_s, u_s}), 32'b01);
                end else begin
                    chk("R8", "single-hit slot flags", 32'({c_s, u_s}), 32'b10);
                    chk("R8", "single-hit slot data", 32'(d_s), 32'(pat(8, s, c)));
                end
            end
        end
    endtask

    task automatic t_clip;
        fill_row(10, 5);
        inj(10, NCOL - 2, 4);
        for (int s = 0; s < ILV; s++) begin
            rd(10, s);
            chk("R9", "clipped data", 32'(d_s), 32'(pat(10, s, 5)));
            chk("R9", "clipped flags", 32'({c_s, u_s}), (s >= 2) ? 32'b10 : 32'b00);
        end
    endtask

    task automatic t_parity;
        wr(5, 1, 16'h1234);
        inj(5, 13, 1);
        rd(5, 1);
        chk("R10", "parity flags", 32'({c_p, u_p}), 32'b01);
        chk("R10", "parity data unrepaired", 32'(d_p), 32'(16'h1234 ^ 16'h0008));
        chk("R5", "secded repairs same flip", 32'(d_s), 32'h1234);
        chk("R5", "secded corr flag", 32'({c_s, u_s}), 32'b10);
    endtask

    task automatic t_hold;
        wr(5, 0, 16'h0f1e);
        rd(5, 0);
        chk("R11", "first read", 32'(d_s), 32'h0f1e);
        repeat (3) @(negedge clk);
        chk("R11", "held while idle", 32'(d_s), 32'h0f1e);
        wr(5, 0, 16'h7777);
        chk("R11", "held across write", 32'(d_s), 32'h0f1e);
        chk("R11", "valid low while idle", 32'(v_s), 0);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_partial();
        t_single();
        t_bursts();
        t_double();
        t_long();
        t_clip();
        t_parity();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule